// File: doc/BRIEF.md
# I2C SCL Period Generator

This block times the clock line of an I2C master. It divides the source clock by an 8-bit divider into count units. It then walks a two-phase sequence, LOW and then HIGH. The length of each phase comes from three 10-bit counts packed into one configuration word: a high count, a low count and a full-cycle count. When the full-cycle count is larger than the high and low counts together, the surplus is added to the low phase, so the period follows the cycle count. Typical settings from a 19.2 MHz source are: divider 7 with high/low/cycle 10/11/26 for 100 kHz, divider 2 with 5/12/24 for 400 kHz, and divider 1 with 3/9/18 for 1 MHz.

The output `scl_low_o` asks an open-drain pad to pull SCL low. The observed line comes back on `scl_i` through a synchronizer. The high phase does not count while the line is seen low, so a target can stretch the clock. Two single-cycle strobes mark the middle of the low phase, where SDA may change, and the middle of the high phase, where SDA is sampled. A byte engine uses these strobes. Divider and counts are captured at reset and at each period boundary, so software may rewrite them at any time.

Top module: `scl_period_gen`

## Requirements
- R1: `timing_i` holds the high count in bits 29:20, the low count in bits 19:10 and the cycle count in bits 9:0. `div_i` is the 8-bit divider.
- R2: One count unit lasts `div_i` source clocks. A divider of 0 behaves as 1.
- R3: The low phase lasts the low count in units. When cycle > high + low, it lasts cycle − high instead. A phase length of 0 behaves as 1.
- R4: The high phase lasts the high count in units. These units are counted only on clocks where the synchronized line (`SYNC_STAGES` flops, reset value 1) reads high; while it reads low, the partial unit restarts. With the default settings and no stretching, the time between rising edges of `scl_low_o` is cycle×divider + 3 clocks.
- R5: While `clk_en` is 0, the prescaler, phase and phase counter hold their values. From the next clock, `scl_low_o` and both strobes are 0. Timing resumes where it stopped once `clk_en` returns to 1.
- R6: Divider and counts are captured during reset and on the clock at which a high phase ends. A value applied at any other time has no effect on the period in progress.
- R7: `low_mid_o` (or `high_mid_o`) pulses for one clock after the unit that ends with the phase counter equal to (length−1)/2, rounded down, in the low (or high) phase. `low_mid_o` is seen only with `scl_low_o`=1 and `high_mid_o` only with `scl_low_o`=0.
- R8: During and after synchronous reset, `scl_low_o`, `low_mid_o` and `high_mid_o` are 0, and the sequence starts at the beginning of a low phase.
- R9: All outputs are registered. `scl_low_o` follows the phase one clock late and equals `clk_en` AND (phase is LOW).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Serial clock enable; timing freezes while 0 |
| div_i | input | 8 | Prescaler divider (0 behaves as 1) |
| timing_i | input | 30 | Packed high/low/cycle counts |
| scl_i | input | 1 | Observed SCL line level |
| scl_low_o | output | 1 | 1 = pull SCL low |
| low_mid_o | output | 1 | Strobe at the middle of the low phase |
| high_mid_o | output | 1 | Strobe at the middle of the high phase |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a configuration rewrite and the tick that closes a high phase. The second is the enable dropping and a prescaler tick. The bench watches its own model state to find the negative edge just before such a boundary or tick, and it changes the configuration or clears the enable at exactly that point. On every clock, the new period length and the suppressed tick are judged against the behavioural model. Clock stretching by a target is mixed into the same runs, so the stall and the boundary events also interact.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_e;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             stall,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] div_eff;

  always_comb begin
    div_eff = (div == '0) ? DIV_W'(1) : div;
    tick    = en && !stall && (pre_q == div_eff - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (en) begin
      if (stall || tick) pre_q <= '0;
      else               pre_q <= pre_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               tick,
  input  logic               scl_seen,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [3*CNT_W-1:0] timing_i,
  output logic               stall,
  output logic [DIV_W-1:0]   div_q,
  output logic               scl_low_q,
  output logic               low_mid_q,
  output logic               high_mid_q
);
  localparam int HI_LSB = 2 * CNT_W;
  localparam int LO_LSB = CNT_W;

  scl_phase_e       phase_q;
  logic [CNT_W-1:0] hi_q, lo_q, cyc_q, cnt_q;
  logic [CNT_W-1:0] hi_len, lo_raw, lo_len, cur_len, mid;
  logic [CNT_W:0]   hl_sum;
  logic             last;

  always_comb begin
    hl_sum  = {1'b0, hi_q} + {1'b0, lo_q};
    hi_len  = (hi_q == '0) ? CNT_W'(1) : hi_q;
    lo_raw  = ({1'b0, cyc_q} > hl_sum) ? (cyc_q - hi_q) : lo_q;
    lo_len  = (lo_raw == '0) ? CNT_W'(1) : lo_raw;
    cur_len = (phase_q == PH_HIGH) ? hi_len : lo_len;
    mid     = (cur_len - CNT_W'(1)) >> 1;
    last    = (cnt_q == cur_len - CNT_W'(1));
    stall   = (phase_q == PH_HIGH) && !scl_seen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_LOW;
      cnt_q      <= '0;
      scl_low_q  <= 1'b0;
      low_mid_q  <= 1'b0;
      high_mid_q <= 1'b0;
      div_q      <= div_i;
      hi_q       <= timing_i[HI_LSB +: CNT_W];
      lo_q       <= timing_i[LO_LSB +: CNT_W];
      cyc_q      <= timing_i[0 +: CNT_W];
    end else begin
      scl_low_q  <= en && (phase_q == PH_LOW);
      low_mid_q  <= tick && (phase_q == PH_LOW)  && (cnt_q == mid);
      high_mid_q <= tick && (phase_q == PH_HIGH) && (cnt_q == mid);
      if (tick) begin
        if (last) begin
          cnt_q <= '0;
          if (phase_q == PH_HIGH) begin
            phase_q <= PH_LOW;
            div_q   <= div_i;
            hi_q    <= timing_i[HI_LSB +: CNT_W];
            lo_q    <= timing_i[LO_LSB +: CNT_W];
            cyc_q   <= timing_i[0 +: CNT_W];
          end else begin
            phase_q <= PH_HIGH;
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CNT_W       = 10,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clk_en,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [3*CNT_W-1:0] timing_i,
  input  logic               scl_i,
  output logic               scl_low_o,
  output logic               low_mid_o,
  output logic               high_mid_o
);
  localparam int CFG_W = 3 * CNT_W;

  logic             scl_seen;
  logic             stall;
  logic             tick;
  logic [DIV_W-1:0] div_live;
  logic [CFG_W-1:0] timing_w;

  assign timing_w = timing_i;

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (scl_i),
    .q   (scl_seen)
  );

  scl_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .en    (clk_en),
    .stall (stall),
    .div   (div_live),
    .tick  (tick)
  );

  scl_phase_seq #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (clk_en),
    .tick       (tick),
    .scl_seen   (scl_seen),
    .div_i      (div_i),
    .timing_i   (timing_w),
    .stall      (stall),
    .div_q      (div_live),
    .scl_low_q  (scl_low_o),
    .low_mid_q  (low_mid_o),
    .high_mid_q (high_mid_o)
  );
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic clk_en,
  input logic scl_i,
  input logic scl_low_o,
  input logic low_mid_o,
  input logic high_mid_o
);
  // R5: a cleared enable releases the line on the next clock
  p_idle_release_r5: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> !scl_low_o);

  // R5: no strobe follows a clock with the enable cleared
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> (!low_mid_o && !high_mid_o));

  // R7: the low-phase strobe appears only while SCL is pulled low
  p_low_mid_in_low_r7: assert property (@(posedge clk) disable iff (rst)
    low_mid_o |-> scl_low_o);

  // R7: the high-phase strobe appears only while SCL is released
  p_high_mid_released_r7: assert property (@(posedge clk) disable iff (rst)
    high_mid_o |-> !scl_low_o);

  // R7: the two strobes never coincide
  p_strobes_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({low_mid_o, high_mid_o}));

  // R4: a high-phase unit only completes after the line was seen high
  p_high_needs_line_r4: assert property (@(posedge clk) disable iff (rst)
    high_mid_o |-> $past(scl_i, SYNC_STAGES + 1));
endmodule

bind scl_period_gen scl_period_gen_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clk_en     (clk_en),
  .scl_i      (scl_i),
  .scl_low_o  (scl_low_o),
  .low_mid_o  (low_mid_o),
  .high_mid_o (high_mid_o)
);

// File: tb/scl_period_gen_tb_top.sv
`timescale 1ns/1ps
module scl_period_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en = 1'b0;
  logic [7:0]  div_i = 8'd7;
  logic [29:0] timing_i = '0;
  logic        hold = 1'b0;
  wire         scl_line;
  logic        scl_low_o, low_mid_o, high_mid_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign scl_line = !(scl_low_o === 1'b1) && !hold;

  scl_period_gen dut_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .div_i(div_i),
    .timing_i(timing_i), .scl_i(scl_line),
    .scl_low_o(scl_low_o), .low_mid_o(low_mid_o), .high_mid_o(high_mid_o)
  );

  // R1: pack counts as high[29:20], low[19:10], cycle[9:0]
  function automatic logic [29:0] pack(int h, int l, int c);
    return {10'(h), 10'(l), 10'(c)};
  endfunction

  // Behavioural reference model
  int m_ph = 0, m_cnt = 0, m_pre = 0, m_s0 = 1, m_s1 = 1;
  int m_div = 0, m_h = 0, m_l = 0, m_c = 0;
  int m_out = 0, m_lm = 0, m_hm = 0;

  function automatic int eff_div();
    return (m_div == 0) ? 1 : m_div;
  endfunction
  function automatic int cur_len();
    int ll;
    if (m_ph == 1) return (m_h == 0) ? 1 : m_h;
    ll = (m_c > m_h + m_l) ? m_c - m_h : m_l;
    return (ll == 0) ? 1 : ll;
  endfunction
  function automatic bit tick_next();
    return clk_en && !(m_ph == 1 && m_s1 == 0) && (m_pre == eff_div() - 1);
  endfunction
  function automatic bit boundary_next();
    return tick_next() && m_ph == 1 && (m_cnt == cur_len() - 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_pre = 0; m_s0 = 1; m_s1 = 1;
      m_out = 0; m_lm = 0; m_hm = 0;
      m_div = div_i; m_h = timing_i[29:20]; m_l = timing_i[19:10]; m_c = timing_i[9:0];
    end else begin
      int wt, nout, lm, hm, len;
      wt = (m_ph == 1) && (m_s1 == 0);
      nout = clk_en && (m_ph == 0);
      lm = 0; hm = 0;
      m_s1 = m_s0; m_s0 = scl_line;
      if (clk_en) begin
        if (wt) m_pre = 0;
        else if (m_pre == eff_div() - 1) begin
          m_pre = 0;
          len = cur_len();
          if (m_cnt == (len - 1) / 2) begin
            if (m_ph == 1) hm = 1; else lm = 1;
          end
          if (m_cnt == len - 1) begin
            m_cnt = 0;
            if (m_ph == 1) begin
              m_ph = 0;
              m_div = div_i; m_h = timing_i[29:20]; m_l = timing_i[19:10]; m_c = timing_i[9:0];
            end else m_ph = 1;
          end else m_cnt++;
        end else m_pre++;
      end
      m_out = nout; m_lm = lm; m_hm = hm;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model (R2 R3 R4 R5 R6 R7 R9)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(scl_low_o === 1'(m_out), "R3/R4/R9", "scl_low_o", int'(scl_low_o), m_out);
      check(low_mid_o === 1'(m_lm), "R7", "low_mid_o", int'(low_mid_o), m_lm);
      check(high_mid_o === 1'(m_hm), "R7", "high_mid_o", int'(high_mid_o), m_hm);
    end
  end

  task automatic wait_rise();
    bit prev;
    prev = scl_low_o;
    forever begin
      @(negedge clk);
      if (!prev && scl_low_o) return;
      prev = scl_low_o;
    end
  endtask

  task automatic count_to_rise(output int n);
    bit prev;
    n = 0;
    prev = scl_low_o;
    forever begin
      @(negedge clk);
      n++;
      if (!prev && scl_low_o) return;
      prev = scl_low_o;
    end
  endtask

  task automatic measure(int exp, string req);
    int n;
    wait_rise();
    count_to_rise(n);
    check(n == exp, req, "period clocks", n, exp);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    timing_i = pack(10, 11, 26); div_i = 8'd7;
    repeat (4) @(negedge clk);
    // R8: outputs quiet during reset
    check(scl_low_o === 1'b0, "R8", "scl_low_o in reset", int'(scl_low_o), 0);
    check(low_mid_o === 1'b0 && high_mid_o === 1'b0, "R8", "strobes in reset",
          int'(low_mid_o | high_mid_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(scl_low_o === 1'b0, "R8", "scl_low_o after reset, disabled", int'(scl_low_o), 0);
    clk_en = 1'b1;
    // R1 R2 R3 R4: 100 kHz style settings
    measure(26 * 7 + 3, "R4");
    // 400 kHz style, extra low time from cycle > high+low (R3)
    div_i = 8'd2; timing_i = pack(5, 12, 24);
    wait_rise();
    measure(24 * 2 + 3, "R3");
    // 1 MHz style
    div_i = 8'd1; timing_i = pack(3, 9, 18);
    wait_rise();
    measure(18 + 3, "R2");
    // R6: rewrite right after a period starts; current period keeps old values
    wait_rise();
    div_i = 8'd3; timing_i = pack(4, 6, 8);
    count_to_rise(n);
    check(n == 21, "R6", "period after mid-period rewrite", n, 21);
    measure(10 * 3 + 3, "R6");
    // R2: divider 0 behaves as 1; R3: zero counts behave as 1
    div_i = 8'd0; timing_i = pack(2, 3, 4);
    repeat (200) @(negedge clk);
    timing_i = pack(0, 0, 0);
    repeat (200) @(negedge clk);
    // R4: clock stretching by a target
    div_i = 8'd1; timing_i = pack(3, 9, 18);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk iff (scl_low_o == 1'b0 && m_ph == 1));
      hold = 1'b1;
      repeat (10 + 7 * k) @(negedge clk);
      hold = 1'b0;
      wait_rise();
    end
    // R5: disable freezes and releases the line
    repeat (5) @(negedge clk);
    clk_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(scl_low_o === 1'b0, "R5", "scl_low_o while disabled", int'(scl_low_o), 0);
    end
    clk_en = 1'b1;
    // Coincident: config rewrite on the boundary tick (R6), enable drop on a tick (R5)
    div_i = 8'd2;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk iff boundary_next());
      div_i = 8'(1 + k % 3); timing_i = pack(2 + k, 3 + k, 4 + 3 * k);
      @(negedge clk iff tick_next());
      clk_en = 1'b0;
      repeat (1 + k) @(negedge clk);
      clk_en = 1'b1;
    end
    // Mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 40) == 0)
        begin div_i = 8'($urandom_range(0, 3));
              timing_i = pack($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 15)); end
      if ($urandom_range(0, 30) == 0) clk_en = !clk_en;
      if ($urandom_range(0, 25) == 0) hold = !hold;
    end
    hold = 1'b0; clk_en = 1'b1;
    repeat (50) @(negedge clk);
    finish_run();
  end
endmodule